// File: doc/BRIEF.md
# Reference PLL Power Sequencer

This block brings the reference PLL of a multi-channel frequency synthesizer up and down in a fixed order. An enable request starts a bring-up. The sequencer releases the PLL reset, selects the clean-reference noise bandwidth and loads the feedback divider. It then drives the power-down pin to its powered-up level and waits for the lock indication. Each step takes one clock cycle.

A disable request runs a two-step shutdown. The power-down pin goes to its powered-down level first. The reset is reasserted in the next cycle.

The lock wait is bounded by a cycle counter. The counter limit is derived from the system clock frequency and a timeout in microseconds, and the default is 10 ms. If lock does not arrive in time, the sequencer sets a sticky error flag and returns to idle.

The power-down pin polarity is a configuration input. The "PLL on" status output compares the pin level against that polarity.

Top module: `pll_power_seq`

## Requirements
- R1: While `rst` is high and after it falls with no request, the outputs hold these values:
  - `pll_rst`=1, `bw_sel`=RST_BW (default 1), `fb_div`=0, `pll_pdn`=`pol_cfg`
  - `pll_on`=0, `seq_done`=0, `lock_err`=0
- R2: When an enable request is accepted in idle, the bring-up steps become visible one per cycle on consecutive clock edges:
  - `pll_rst` falls one edge after the request cycle.
  - `bw_sel` becomes 0 (clean reference; code 1 = very noisy, 2 = noisy, 3 = very clean) on the next edge.
  - `fb_div` is loaded on the edge after that.
  - `pll_pdn` reaches its powered-up level on the edge after that.
- R3: `fb_div` takes the value of `fb_div_in` sampled in the request cycle. This 3-bit register value equals the multiplication factor minus 16. Later changes of `fb_div_in` have no effect.
- R4: The powered-up level of `pll_pdn` is the inverse of `pol_cfg`. The powered-down level equals `pol_cfg`.
- R5: If `lock_in` is sampled high during the wait, `seq_done` is high for exactly one cycle after that edge.
- R6: If `lock_in` stays low for LIMIT = CLK_HZ/1e6 × LOCK_TIMEOUT_US wait cycles, the following happen:
  - `lock_err` sets, `seq_done` stays low and the PLL stays powered.
  - A lock seen in the last allowed wait cycle still counts as success.
- R7: On an accepted disable request, `pll_pdn` goes to `pol_cfg` one edge later. `pll_rst` rises on the following edge, together with a one-cycle `seq_done`.
- R8: `pll_on` is 1 exactly when `pll_pdn` differs from `pol_cfg`.
- R9: Enable or disable requests that arrive while a sequence is running are ignored.
- R10: If enable and disable are requested in the same idle cycle, the disable sequence runs.
- R11: `lock_err` stays set until the next accepted request. It clears on that request's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Bring-up request |
| dis_req | input | 1 | Shutdown request |
| fb_div_in | input | DIV_W | Feedback divider register value (factor − 16) |
| lock_in | input | 1 | PLL lock indication |
| pol_cfg | input | 1 | Level of `pll_pdn` meaning powered down |
| pll_rst | output | 1 | PLL block reset, active high |
| bw_sel | output | 2 | Input-noise bandwidth code |
| fb_div | output | DIV_W | Feedback divider to the PLL |
| pll_pdn | output | 1 | Power-down pin |
| pll_on | output | 1 | PLL powered-up status |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |
| lock_err | output | 1 | Sticky lock-timeout flag |

## Verification
Lock detection and timeout expiry can fall in the same cycle. This happens when `lock_in` first rises in the last allowed wait cycle. The bench provokes the case by placing a one-cycle lock pulse exactly at index LIMIT−1, and also at random positions on both sides of the limit. It judges the result by requiring a `seq_done` pulse with `lock_err` low. The bench also drives enable and disable in the same idle cycle and expects the shutdown ordering on the pins.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    // Input-noise bandwidth codes
    typedef enum logic [1:0] {
        BW_CLEAN     = 2'd0,
        BW_NOISIEST  = 2'd1,
        BW_NOISY     = 2'd2,
        BW_CLEANEST  = 2'd3
    } bw_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BW,
        ST_DIV,
        ST_PWR,
        ST_WAIT,
        ST_RSTON
    } seq_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RST_OFF,
        ACT_BW,
        ACT_DIV,
        ACT_PWR_ON,
        ACT_PWR_OFF,
        ACT_RST_ON
    } seq_act_e;

    // Per-cycle command from controller to pin bank
    typedef struct packed {
        seq_act_e act;
        logic     done;
        logic     fail;
        logic     clr_err;
    } seq_cmd_t;

    // Lock wait length in clock cycles
    function automatic int unsigned wait_cycles(int unsigned clk_hz, int unsigned tmo_us);
        return (clk_hz / 32'd1_000_000) * tmo_us;
    endfunction

    // Pin level for a requested power state under a given polarity
    function automatic logic pdn_level(logic pol, logic power_on);
        return power_on ? ~pol : pol;
    endfunction

endpackage

// File: rtl/pllseq_lock_timer.sv
module pllseq_lock_timer #(
    parameter int unsigned LIMIT = 500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R6

    AST_TMR_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_req,
    input  logic     dis_req,
    input  logic     lock_in,
    input  logic     expired,
    output seq_cmd_t cmd,
    output logic     tmr_clr,
    output logic     tmr_run
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d    = st_q;
        cmd     = '{act: ACT_NONE, done: 1'b0, fail: 1'b0, clr_err: 1'b0};
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (dis_req) begin            // disable wins a tie
                    cmd.act     = ACT_PWR_OFF;
                    cmd.clr_err = 1'b1;
                    st_d        = ST_RSTON;
                end else if (en_req) begin
                    cmd.act     = ACT_RST_OFF;
                    cmd.clr_err = 1'b1;
                    st_d        = ST_BW;
                end
            end
            ST_BW: begin
                cmd.act = ACT_BW;
                st_d    = ST_DIV;
            end
            ST_DIV: begin
                cmd.act = ACT_DIV;
                st_d    = ST_PWR;
            end
            ST_PWR: begin
                cmd.act = ACT_PWR_ON;
                tmr_clr = 1'b1;
                st_d    = ST_WAIT;
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                if (lock_in) begin            // lock beats expiry
                    cmd.done = 1'b1;
                    st_d     = ST_IDLE;
                end else if (expired) begin
                    cmd.fail = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            ST_RSTON: begin
                cmd.act  = ACT_RST_ON;
                cmd.done = 1'b1;
                st_d     = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    AST_BW_THEN_DIV: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BW) |=> (st_q == ST_DIV)); // R2

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DIV) |=> (st_q == ST_PWR)); // R9

    AST_LOCK_EXITS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && lock_in) |=> (st_q == ST_IDLE)); // R5

    AST_TIE_DISABLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && en_req && dis_req) |=> (st_q == ST_RSTON)); // R10

endmodule

// File: rtl/pllseq_pins.sv
module pllseq_pins
    import pllseq_pkg::*;
#(
    parameter int         DIV_W  = 3,
    parameter logic [1:0] RST_BW = 2'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pol_cfg,
    input  seq_cmd_t         cmd,
    input  logic [DIV_W-1:0] div_in,
    output logic             pll_rst,
    output logic [1:0]       bw_sel,
    output logic [DIV_W-1:0] fb_div,
    output logic             pll_pdn,
    output logic             seq_done,
    output logic             lock_err
);
    logic [DIV_W-1:0] div_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_rst    <= 1'b1;
            bw_sel     <= RST_BW;
            fb_div     <= '0;
            div_hold_q <= '0;
            pll_pdn    <= pdn_level(pol_cfg, 1'b0);
            seq_done   <= 1'b0;
            lock_err   <= 1'b0;
        end else begin
            seq_done <= cmd.done;
            if (cmd.clr_err)   lock_err <= 1'b0;
            else if (cmd.fail) lock_err <= 1'b1;
            case (cmd.act)
                ACT_RST_OFF: begin
                    pll_rst    <= 1'b0;
                    div_hold_q <= div_in;
                end
                ACT_BW:      bw_sel  <= BW_CLEAN;
                ACT_DIV:     fb_div  <= div_hold_q;
                ACT_PWR_ON:  pll_pdn <= pdn_level(pol_cfg, 1'b1);
                ACT_PWR_OFF: pll_pdn <= pdn_level(pol_cfg, 1'b0);
                ACT_RST_ON:  pll_rst <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pll_power_seq.sv
module pll_power_seq
    import pllseq_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 50_000_000,
    parameter int unsigned LOCK_TIMEOUT_US = 10_000,
    parameter int          DIV_W           = 3,
    parameter logic [1:0]  RST_BW          = 2'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic [DIV_W-1:0] fb_div_in,
    input  logic             lock_in,
    input  logic             pol_cfg,
    output logic             pll_rst,
    output logic [1:0]       bw_sel,
    output logic [DIV_W-1:0] fb_div,
    output logic             pll_pdn,
    output logic             pll_on,
    output logic             seq_done,
    output logic             lock_err
);
    localparam int unsigned LIMIT = wait_cycles(CLK_HZ, LOCK_TIMEOUT_US);

    seq_cmd_t cmd;
    logic     tmr_clr, tmr_run, expired;

    pllseq_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_req  (en_req),
        .dis_req (dis_req),
        .lock_in (lock_in),
        .expired (expired),
        .cmd     (cmd),
        .tmr_clr (tmr_clr),
        .tmr_run (tmr_run)
    );

    pllseq_lock_timer #(.LIMIT(LIMIT)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (expired)
    );

    pllseq_pins #(.DIV_W(DIV_W), .RST_BW(RST_BW)) i_pins (
        .clk      (clk),
        .rst      (rst),
        .pol_cfg  (pol_cfg),
        .cmd      (cmd),
        .div_in   (fb_div_in),
        .pll_rst  (pll_rst),
        .bw_sel   (bw_sel),
        .fb_div   (fb_div),
        .pll_pdn  (pll_pdn),
        .seq_done (seq_done),
        .lock_err (lock_err)
    );

    assign pll_on = pll_pdn ^ pol_cfg; // R8

    AST_PWR_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_on) |-> (!pll_rst && bw_sel == BW_CLEAN)); // R2

    AST_RST_AFTER_PDN: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_rst) |-> (!pll_on && seq_done)); // R7

    AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (rst)
        !(seq_done && $rose(lock_err))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done); // R5

    AST_ERR_KEEPS_POWER: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_err) |-> pll_on); // R6

    initial begin
        assert (LIMIT >= 2); // R6
    end

endmodule

// File: tb/test_pll_power_seq.sv
module test_pll_power_seq;
    localparam int         DIV_W = 3;
    localparam int         LIM   = 50;      // 1 us at 50 MHz
    localparam logic [1:0] RBW   = 2'd1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1, en_req = 1'b0, dis_req = 1'b0, lock_in = 1'b0, pol_cfg = 1'b0;
    logic [DIV_W-1:0] fb_div_in = '0;
    logic             pll_rst, pll_pdn, pll_on, seq_done, lock_err;
    logic [1:0]       bw_sel;
    logic [DIV_W-1:0] fb_div;

    pll_power_seq #(.CLK_HZ(50_000_000), .LOCK_TIMEOUT_US(1), .DIV_W(DIV_W), .RST_BW(RBW))
    i_pll_power_seq (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .fb_div_in(fb_div_in),
        .lock_in(lock_in), .pol_cfg(pol_cfg), .pll_rst(pll_rst), .bw_sel(bw_sel),
        .fb_div(fb_div), .pll_pdn(pll_pdn), .pll_on(pll_on), .seq_done(seq_done),
        .lock_err(lock_err)
    );

    int  total = 0, bad = 0;
    bit  finished = 1'b0;
    logic       m_rst, m_pdn, m_err;
    logic [1:0] m_bw;
    logic [2:0] m_div;

    function automatic logic lvl(logic p, logic on);
        return on ? ~p : p;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic p);
        @(negedge clk);
        pol_cfg = p; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pll_rst", pll_rst, 1);
        chk("R1", "bw_sel", bw_sel, RBW);
        chk("R1", "fb_div", fb_div, 0);
        chk("R1", "pll_pdn", pll_pdn, p);
        chk("R1", "pll_on", pll_on, 0);
        chk("R1", "done/err", {seq_done, lock_err}, 0);
        m_rst = 1'b1; m_pdn = p; m_bw = RBW; m_div = '0; m_err = 1'b0;
    endtask

    task automatic run_enable(logic [2:0] d, int lat, bit noise);
        @(negedge clk);
        en_req = 1'b1; fb_div_in = d;
        @(negedge clk);
        en_req = 1'b0; fb_div_in = ~d; dis_req = noise;
        chk("R2", "pll_rst released", pll_rst, 0);
        chk("R2", "bw_sel not yet", bw_sel, m_bw);
        chk("R11", "err cleared on request", lock_err, 0);
        @(negedge clk);
        dis_req = 1'b0;
        chk("R2", "bw_sel clean", bw_sel, 0);
        chk("R2", "fb_div not yet", fb_div, m_div);
        chk("R9", "pdn unmoved by busy disable", pll_pdn, m_pdn);
        @(negedge clk);
        chk("R3", "fb_div captured", fb_div, d);
        chk("R2", "pdn not yet", pll_pdn, m_pdn);
        @(negedge clk);
        chk("R4", "pdn powered level", pll_pdn, lvl(pol_cfg, 1'b1));
        chk("R8", "pll_on", pll_on, 1);
        m_rst = 1'b0; m_bw = 2'd0; m_div = d; m_pdn = ~pol_cfg;
        for (int i = 0; i < LIM + 2; i++) begin
            lock_in = (i == lat);
            dis_req = noise && (i == 0);
            @(negedge clk);
            lock_in = 1'b0; dis_req = 1'b0;
            if (i == lat && lat < LIM) begin
                chk("R5", "done on lock", seq_done, 1);
                chk("R6", "no err on lock", lock_err, 0);
                m_err = 1'b0;
                break;
            end
            if (i == LIM - 1) begin
                chk("R6", "err at limit", lock_err, 1);
                chk("R6", "no done at limit", seq_done, 0);
                m_err = 1'b1;
                break;
            end
            chk("R5", "waiting no done", seq_done, 0);
        end
        @(negedge clk);
        chk("R5", "done pulse width", seq_done, 0);
        chk("R9", "pdn still powered", pll_pdn, m_pdn);
        chk("R11", "err hold", lock_err, m_err);
        chk("R6", "pll stays on", pll_on, 1);
    endtask

    task automatic run_disable(bit noise, bit also_en);
        @(negedge clk);
        dis_req = 1'b1; en_req = also_en;
        @(negedge clk);
        dis_req = 1'b0; en_req = noise;
        chk(also_en ? "R10" : "R7", "pdn powered down", pll_pdn, pol_cfg);
        chk(also_en ? "R10" : "R7", "reset not yet", pll_rst, m_rst);
        chk("R7", "no done yet", seq_done, 0);
        chk("R11", "err cleared", lock_err, 0);
        @(negedge clk);
        en_req = 1'b0;
        chk("R7", "reset asserted", pll_rst, 1);
        chk("R7", "done pulse", seq_done, 1);
        chk("R8", "pll_on off", pll_on, 0);
        m_rst = 1'b1; m_pdn = pol_cfg; m_err = 1'b0;
        @(negedge clk);
        chk("R7", "done cleared", seq_done, 0);
        @(negedge clk);
        chk("R9", "busy enable ignored", pll_rst, 1);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        do_reset(1'b0);
        run_enable(3'd5, 3, 1'b0);
        run_disable(1'b0, 1'b0);
        run_enable(3'd2, LIM - 1, 1'b1);     // lock on last allowed cycle
        run_disable(1'b1, 1'b0);
        run_enable(3'd7, LIM + 3, 1'b0);     // timeout
        repeat (4) @(negedge clk);
        chk("R11", "err sticky", lock_err, 1);
        run_disable(1'b0, 1'b0);
        run_enable(3'd1, 0, 1'b0);
        run_disable(1'b0, 1'b1);             // R10 tie
        do_reset(1'b1);
        run_enable(3'd0, 0, 1'b1);
        run_enable(3'd6, LIM + 1, 1'b0);
        run_disable(1'b1, 1'b1);
        for (int k = 0; k < 14; k++) begin
            if ($urandom % 4 == 0) do_reset(1'($urandom % 2));
            run_enable(3'($urandom % 8), int'($urandom % (LIM + 10)), 1'($urandom % 2));
            if ($urandom % 2 == 0) run_disable(1'($urandom % 2), 1'($urandom % 2));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule